// File: doc/BRIEF.md
# Wiper Power-Up Recall and Non-Volatile Commit Sequencer

This block owns the wiper registers of a dual digital potentiometer and controls the non-volatile side of its controller. When power-on reset is asserted, every wiper goes to midscale and the serial interface is held busy. A settle counter on the system clock then runs. When it expires, the block copies the stored initial values (supplied by the non-volatile array) into the wipers and raises a sticky ready flag.

In normal operation the serial interface front end reports each STOP condition. It also reports whether the write that this STOP ends needs a non-volatile commit, and gives that write's address and data. For a qualifying STOP, the sequencer captures the address and data and drives a self-timed programming window of fixed length toward the array. Busy stays high for that whole window, and the interface releases SDA and ignores the bus while busy is high. Volatile wiper writes from the interface, and commit requests that arrive while busy is high, are dropped. A master therefore has to poll for an acknowledge.

Top module: `nv_seq`

## Requirements
- R1: While rst_n is low, every wiper reads PRESET (80h by default), busy is 1, ready is 0 and prog_en is 0.
- R2: For the first SETTLE_CYC rising edges after rst_n goes high, every wiper stays at PRESET, ready stays 0 and busy stays 1.
- R3: On rising edge SETTLE_CYC+1 after reset release, each wiper k takes stored_val[k*DW +: DW], ready becomes 1 and busy becomes 0. Ready then stays 1 until the next reset.
- R4: Suppose stop_det and cmt_req are both 1 at a rising edge while busy is 0. From the next cycle on, prog_en and busy are 1 for exactly WRITE_CYC cycles. prog_done is 1 only in the last of these cycles, and busy is 0 afterwards.
- R5: During a programming window, prog_addr and prog_data hold the cmt_addr and cmt_data sampled at the starting STOP, whatever those inputs do later.
- R6: A STOP with cmt_req at 0 (a read, or a write to volatile registers only) starts no programming window, and busy stays 0.
- R7: A STOP with cmt_req at 1 that arrives while busy is 1 is dropped. This applies during recall and during a window, including its last cycle. The dropped STOP starts no later window.
- R8: With busy at 0, a wpr_we pulse writes wpr_data into the wiper selected by wpr_sel (wiper 0 at bits 7:0, wiper 1 at bits 15:8) on the next edge and leaves the other wiper unchanged. With busy at 1, wpr_we has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| stop_det | input | 1 | One-cycle pulse: STOP condition seen on the bus |
| cmt_req | input | 1 | The transaction ended by this STOP needs a non-volatile commit |
| cmt_addr | input | AW (3) | Byte address of the pending commit |
| cmt_data | input | DW (8) | Data byte of the pending commit |
| wpr_we | input | 1 | Volatile wiper write strobe from the interface |
| wpr_sel | input | SW (1) | Wiper index for the volatile write |
| wpr_data | input | DW (8) | Volatile wiper write value |
| stored_val | input | NWIP*DW (16) | Stored initial values, wiper k at bits k*DW +: DW |
| wiper | output | NWIP*DW (16) | Current wiper positions, same packing |
| ready | output | 1 | Power-up recall complete |
| busy | output | 1 | Recall or programming in progress; bus must be ignored |
| prog_en | output | 1 | Programming window active toward the array |
| prog_addr | output | AW (3) | Captured commit address |
| prog_data | output | DW (8) | Captured commit data |
| prog_done | output | 1 | Last cycle of the programming window |

## Verification
The properties take three things for granted about the inputs. stop_det is a clean single-cycle strobe. stored_val is stable around the recall edge. rst_n is the only way back to midscale. The bench drives every input on the falling clock edge, holds stored_val constant from reset until recall completes, and issues each STOP as a one-cycle pulse. It also deliberately lands STOP and wiper-write pulses inside recall, in the middle of a window and on its final cycle, to exercise the drop behaviour.

// File: rtl/nv_seq.sv
module nv_seq #(
  parameter int DW         = 8,
  parameter int NWIP       = 2,
  parameter int AW         = 3,
  parameter int PRESET     = 128,
  parameter int SETTLE_CYC = 750000,
  parameter int WRITE_CYC  = 5000000,
  localparam int SW = (NWIP > 1) ? $clog2(NWIP) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stop_det,
  input  logic                 cmt_req,
  input  logic [AW-1:0]        cmt_addr,
  input  logic [DW-1:0]        cmt_data,
  input  logic                 wpr_we,
  input  logic [SW-1:0]        wpr_sel,
  input  logic [DW-1:0]        wpr_data,
  input  logic [NWIP*DW-1:0]   stored_val,
  output logic [NWIP*DW-1:0]   wiper,
  output logic                 ready,
  output logic                 busy,
  output logic                 prog_en,
  output logic [AW-1:0]        prog_addr,
  output logic [DW-1:0]        prog_data,
  output logic                 prog_done
);

  localparam int MAXC = (SETTLE_CYC > WRITE_CYC) ? SETTLE_CYC : WRITE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] WRITE_LAST  = CW'(WRITE_CYC - 1);

  typedef enum logic [1:0] {ST_PRE, ST_LOAD, ST_IDLE, ST_PROG} st_t;

  st_t           st;
  logic [CW-1:0] cnt;

  wire idle      = (st == ST_IDLE);
  wire start_cmt = idle && stop_det && cmt_req;
  wire cnt_last  = (st == ST_PRE) ? (cnt == SETTLE_LAST) : (cnt == WRITE_LAST);

  assign busy      = !idle;
  assign prog_en   = (st == ST_PROG);
  assign prog_done = prog_en && cnt_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_PRE;
      cnt   <= '0;
      ready <= 1'b0;
    end else begin
      case (st)
        ST_PRE: begin
          if (cnt_last) begin
            st  <= ST_LOAD;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_LOAD: begin
          st    <= ST_IDLE;
          ready <= 1'b1;
        end
        ST_IDLE: begin
          if (start_cmt) begin
            st  <= ST_PROG;
            cnt <= '0;
          end
        end
        default: begin
          if (cnt_last) begin
            st  <= ST_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_addr <= '0;
      prog_data <= '0;
    end else if (start_cmt) begin
      prog_addr <= cmt_addr;
      prog_data <= cmt_data;
    end
  end

  for (genvar k = 0; k < NWIP; k++) begin : g_wip
    logic [DW-1:0] pos_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pos_q <= DW'(PRESET);
      else if (st == ST_LOAD)
        pos_q <= stored_val[k*DW +: DW];
      else if (idle && wpr_we && wpr_sel == SW'(k))
        pos_q <= wpr_data;
    end
    assign wiper[k*DW +: DW] = pos_q;
  end

endmodule

// File: rtl/nv_seq_chk.sv
module nv_seq_chk #(
  parameter int DW = 8,
  parameter int NWIP = 2,
  parameter int AW = 3,
  parameter int PRESET = 128
) (
  input logic               clk,
  input logic               rst_n,
  input logic               stop_det,
  input logic               cmt_req,
  input logic [NWIP*DW-1:0] stored_val,
  input logic [NWIP*DW-1:0] wiper,
  input logic               ready,
  input logic               busy,
  input logic               prog_en,
  input logic [AW-1:0]      prog_addr,
  input logic [DW-1:0]      prog_data,
  input logic               prog_done
);
  localparam logic [NWIP*DW-1:0] MIDALL = {NWIP{DW'(PRESET)}};

  AST_PRE_MIDSCALE: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (busy && wiper == MIDALL && !prog_en)); // R2
  AST_RECALL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (wiper == $past(stored_val) && !busy)); // R3
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready); // R3
  AST_PROG_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |-> (busy && ready)); // R4
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> !busy); // R4
  AST_PROG_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && !prog_done) |=> prog_en); // R7
  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && !prog_done) |=> ($stable(prog_addr) && $stable(prog_data))); // R5
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(stop_det && cmt_req)) |=> !prog_en); // R6
  AST_WIPER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ready) |=> $stable(wiper)); // R8
endmodule

bind nv_seq nv_seq_chk #(.DW(DW), .NWIP(NWIP), .AW(AW), .PRESET(PRESET)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_det(stop_det), .cmt_req(cmt_req),
  .stored_val(stored_val), .wiper(wiper), .ready(ready), .busy(busy),
  .prog_en(prog_en), .prog_addr(prog_addr), .prog_data(prog_data),
  .prog_done(prog_done)
);

// File: tb/tb_nv_seq.sv
module tb_nv_seq;
  localparam int SETTLE = 20;
  localparam int WCYC   = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stop_det = 1'b0, cmt_req = 1'b0;
  logic [2:0]  cmt_addr = '0;
  logic [7:0]  cmt_data = '0;
  logic        wpr_we = 1'b0;
  logic [0:0]  wpr_sel = '0;
  logic [7:0]  wpr_data = '0;
  logic [15:0] stored_val = 16'h3CA5;
  logic [15:0] wiper;
  logic        ready, busy, prog_en, prog_done;
  logic [2:0]  prog_addr;
  logic [7:0]  prog_data;

  int n_cmp = 0, n_bad = 0, run_len = 0;
  bit finished = 0;
  logic [10:0] exp_q[$];

  always #2 clk = ~clk;

  nv_seq #(.SETTLE_CYC(SETTLE), .WRITE_CYC(WCYC)) dut (
    .clk(clk), .rst_n(rst_n), .stop_det(stop_det), .cmt_req(cmt_req),
    .cmt_addr(cmt_addr), .cmt_data(cmt_data), .wpr_we(wpr_we),
    .wpr_sel(wpr_sel), .wpr_data(wpr_data), .stored_val(stored_val),
    .wiper(wiper), .ready(ready), .busy(busy), .prog_en(prog_en),
    .prog_addr(prog_addr), .prog_data(prog_data), .prog_done(prog_done));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && prog_en) begin
      run_len++;
      if (prog_done) begin
        if (exp_q.size() == 0) begin
          chk(0, "R7 unexpected window", {prog_addr, prog_data}, 0);
        end else begin
          logic [10:0] e;
          e = exp_q.pop_front();
          chk({prog_addr, prog_data} == e, "R5 captured addr/data", {prog_addr, prog_data}, e);
          chk(run_len == WCYC, "R4 window length", run_len, WCYC);
        end
        run_len = 0;
      end
    end
  end

  task automatic commit(input logic [2:0] a, input logic [7:0] d);
    stop_det = 1; cmt_req = 1; cmt_addr = a; cmt_data = d;
    exp_q.push_back({a, d});
    step(1);
    stop_det = 0; cmt_req = 0;
  endtask

  initial begin
    step(2);
    chk(wiper == 16'h8080, "R1 wiper preset", wiper, 16'h8080);
    chk(busy && !ready && !prog_en, "R1 flags", {busy, ready, prog_en}, 3'b100);
    rst_n = 1;
    step(3);
    stop_det = 1; cmt_req = 1; wpr_we = 1; wpr_data = 8'hEE;
    step(1);
    stop_det = 0; cmt_req = 0; wpr_we = 0;
    step(SETTLE - 4);
    chk(wiper == 16'h8080, "R2 still preset", wiper, 16'h8080);
    chk(!ready && busy, "R2 not ready", {ready, busy}, 2'b01);
    step(1);
    chk(wiper == 16'h3CA5, "R3 recalled", wiper, 16'h3CA5);
    chk(ready && !busy, "R3 ready", {ready, busy}, 2'b10);
    step(2);
    chk(!prog_en, "R7 recall-time request dropped", prog_en, 0);

    wpr_we = 1; wpr_sel = 1; wpr_data = 8'h5A;
    step(1);
    wpr_we = 0;
    chk(wiper == 16'h5AA5, "R8 idle wiper write", wiper, 16'h5AA5);

    stop_det = 1; cmt_req = 0; cmt_addr = 3'd4; cmt_data = 8'h99;
    step(1);
    stop_det = 0;
    chk(!busy && !prog_en, "R6 volatile stop", {busy, prog_en}, 0);
    step(3);
    chk(!prog_en, "R6 still idle", prog_en, 0);

    commit(3'd3, 8'hC7);
    chk(busy && prog_en, "R4 window starts", {busy, prog_en}, 2'b11);
    cmt_addr = 3'd6; cmt_data = 8'h01;
    stop_det = 1; cmt_req = 1; wpr_we = 1; wpr_sel = 0; wpr_data = 8'h00;
    step(1);
    stop_det = 0; cmt_req = 0; wpr_we = 0;
    chk(prog_addr == 3'd3 && prog_data == 8'hC7, "R5 mid-window", {prog_addr, prog_data}, {3'd3, 8'hC7});
    while (!prog_done) step(1);
    stop_det = 1; cmt_req = 1; cmt_addr = 3'd5; cmt_data = 8'h42;
    step(1);
    stop_det = 0; cmt_req = 0;
    chk(!busy, "R4 busy clear after window", busy, 0);
    chk(wiper == 16'h5AA5, "R8 write during busy ignored", wiper, 16'h5AA5);
    step(2);
    chk(!prog_en, "R7 last-cycle request dropped", prog_en, 0);

    commit(3'd0, 8'h11);
    step(WCYC + 2);
    chk(!busy && exp_q.size() == 0, "R4 second commit consumed", exp_q.size(), 0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule